// File: doc/BRIEF.md
# Dual-Channel Status Buffer Reader

This block keeps the channel-status bits received for two sub-channels, A and B, in two stages. A capture stage is written word by word from the receiver side. On request, the whole capture stage is copied in one clock into a host-visible stage. The host reads the host-visible stage one byte at a time through a byte-wide read port with an auto-incrementing word index. Each 16-bit word holds the channel A byte in bits 15:8 and the channel B byte in bits 7:0.

Configuration inputs choose the read mode. In one-byte mode, each read returns the A or the B byte of a word, and a channel-select input picks which. In two-byte mode, each word is returned as two reads, A first and then B. A buffer-select input unmaps the store, and reads then return zero. A copy that changes at least one stored bit sets a sticky event flag. The flag drives the interrupt output through a mask input. A copy requested while the host holds a read burst open is deferred until the burst closes, so the host never sees a half-updated block.

Top module: `chstat_reader`

## Requirements
- R1: After reset, both stages hold zero, `irq` and `rd_valid` are low, `rd_data` is zero, and the word index is 0 with the A byte next.
- R2: A capture write (`cap_we`, `cap_addr` below 24) updates only the capture stage. Host reads return the old host-visible contents until a copy takes place.
- R3: A `xfer_req` pulse sampled while `burst_active` is low copies all 24 capture words into the host-visible stage at that clock edge.
- R4: A copy that changes any bit of the host-visible stage sets the event flag. `irq` equals the event flag ANDed with `irq_en`.
- R5: A copy that leaves every host-visible bit unchanged does not set the event flag.
- R6: The event flag stays set until an `irq_clr` pulse clears it. If a copy sets the flag in the same cycle as a clear, the set wins.
- R7: While `irq_en` is 0, `irq` is low, and the event flag is kept. Setting `irq_en` to 1 later exposes the kept flag.
- R8: In one-byte mode (`two_byte`=0), each read returns bits 15:8 of the current word when `chan_b`=0, or bits 7:0 when `chan_b`=1. The word index advances by one after every read.
- R9: In two-byte mode (`two_byte`=1), each word gives bits 15:8 on the first read and bits 7:0 on the second. The word index advances only after the second read.
- R10: The word index wraps from 23 to 0.
- R11: A copy requested while `burst_active` is high is held. The host-visible stage stays unchanged while the burst lasts. The copy takes effect at the first clock edge at which `burst_active` is sampled low.
- R12: While `buf_sel` is 1, reads return 0x00, and the word index still advances as in R8 and R9.
- R13: `rd_load` sets the word index to `rd_addr`, or to 0 if `rd_addr` is above 23, and selects the A byte next. A read strobed in the same cycle as `rd_load` is dropped.
- R14: For each accepted read, `rd_data` holds the byte and `rd_valid` is high for exactly the one cycle after `rd_strobe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_we | input | 1 | Capture-stage write enable |
| cap_addr | input | 5 | Capture word address (0..23) |
| cap_data | input | 16 | Capture word, A byte in bits 15:8, B byte in bits 7:0 |
| xfer_req | input | 1 | Request a copy from the capture stage to the host-visible stage |
| burst_active | input | 1 | High while a host read burst is open |
| buf_sel | input | 1 | 0 maps the status store, 1 makes reads return zero |
| two_byte | input | 1 | 1 selects two-byte mode, 0 selects one-byte mode |
| chan_b | input | 1 | One-byte mode: 1 returns the B byte, 0 the A byte |
| irq_en | input | 1 | Interrupt mask, 1 enables |
| irq_clr | input | 1 | Write-one pulse that clears the event flag |
| rd_load | input | 1 | Load the word index from `rd_addr` |
| rd_addr | input | 5 | Start word for `rd_load` |
| rd_strobe | input | 1 | Read one byte |
| rd_data | output | 8 | Byte returned by the last read |
| rd_valid | output | 1 | `rd_data` valid this cycle |
| irq | output | 1 | Masked change interrupt |

## Verification
Some properties are checked on every cycle. The mask must hold `irq` low, the event flag must persist without a clear, and a copy with identical contents must not raise the flag. The host-visible stage must stay frozen while a burst is open. Every accepted read must give a single valid pulse, an unmapped read must give zero, and the word index must stay below 24. Other behaviour only the bench's scenarios can show, because the expected bytes come from a separate model of both stages. This covers the byte order of each mode, the channel choice, the wrap from word 23, the deferred copy taking effect after the burst, and the set-over-clear priority.

// File: rtl/chstat_pkg.sv
// Package: shared types for the dual-channel status buffer reader.
// Assumes nothing beyond standard SystemVerilog.
package chstat_pkg;
    // Which half of a paired A/B word the next two-byte-mode read returns.
    typedef enum logic {
        HALF_A = 1'b0,
        HALF_B = 1'b1
    } half_e;
endpackage

// File: rtl/chstat_capture.sv
// Capture stage: NWORDS words written from the receiver side.
// Assumes that addresses at or above NWORDS are invalid, and it drops them.
// The whole stage is presented flat, so that the copy unit can take it in one step.
module chstat_capture #(
    parameter int NWORDS = 24,
    parameter int WORD_W = 16,
    parameter int AW     = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [AW-1:0]            waddr,
    input  logic [WORD_W-1:0]        wdata,
    output logic [NWORDS*WORD_W-1:0] d_flat
);
    logic [WORD_W-1:0] mem [NWORDS];

    // Writes one capture word, or clears the whole stage on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NWORDS; i++) mem[i] <= '0;
        end else if (we && (int'(waddr) < NWORDS)) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < NWORDS; g++) begin : g_flat
        assign d_flat[g*WORD_W +: WORD_W] = mem[g];
    end
endmodule

// File: rtl/chstat_xfer.sv
// Copy unit: holds the host-visible stage and copies the capture stage into it.
// A request that arrives during a read burst is held until the burst closes.
// The event flag is set when a copy changes any bit. It is sticky and is cleared
// by a write-one pulse. A set in the same cycle as a clear wins.
module chstat_xfer #(
    parameter int NWORDS = 24,
    parameter int WORD_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NWORDS*WORD_W-1:0] d_flat,
    input  logic                     xfer_req,
    input  logic                     burst_active,
    input  logic                     irq_clr,
    output logic [NWORDS*WORD_W-1:0] e_flat,
    output logic                     irq_flag
);
    logic pending;
    logic fire;
    logic differs;

    // A copy fires when a request is new or held, and no burst is open.
    assign fire    = (xfer_req || pending) && !burst_active;
    // Parallel compare of the whole block against the current host-visible stage.
    assign differs = (d_flat != e_flat);

    // Holds a deferred request across an open burst.
    always_ff @(posedge clk) begin
        if (!rst_n) pending <= 1'b0;
        else        pending <= (xfer_req || pending) && burst_active;
    end

    // Copies the capture stage into the host-visible stage in one step.
    always_ff @(posedge clk) begin
        if (!rst_n)    e_flat <= '0;
        else if (fire) e_flat <= d_flat;
    end

    // Sticky change flag; a set beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                irq_flag <= 1'b0;
        else if (fire && differs)  irq_flag <= 1'b1;
        else if (irq_clr)          irq_flag <= 1'b0;
    end
endmodule

// File: rtl/chstat_rdseq.sv
// Read sequencer: returns bytes of the host-visible stage through an
// auto-incrementing word index. One-byte mode picks A or B per word and
// advances each read. Two-byte mode gives A then B and advances after B.
// Assumes at most one of rd_load and rd_strobe acts per cycle; a load wins.
module chstat_rdseq
    import chstat_pkg::*;
#(
    parameter int NWORDS = 24,
    parameter int BYTE_W = 8,
    parameter int AW     = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NWORDS*2*BYTE_W-1:0] e_flat,
    input  logic                       rd_load,
    input  logic [AW-1:0]              rd_addr,
    input  logic                       rd_strobe,
    input  logic                       two_byte,
    input  logic                       chan_b,
    input  logic                       buf_sel,
    output logic [BYTE_W-1:0]          rd_data,
    output logic                       rd_valid,
    output logic [AW-1:0]              word_idx
);
    localparam int           WORD_W = 2 * BYTE_W;
    localparam logic [AW-1:0] LAST  = AW'(NWORDS - 1);

    half_e             half;
    logic [WORD_W-1:0] cur_word;
    logic [BYTE_W-1:0] pick;
    logic              take_b;
    logic              step;
    logic              accept;
    logic [AW-1:0]     next_idx;

    assign accept   = rd_strobe && !rd_load;
    assign cur_word = e_flat[word_idx*WORD_W +: WORD_W];
    assign take_b   = two_byte ? (half == HALF_B) : chan_b;
    assign pick     = buf_sel ? '0 : (take_b ? cur_word[BYTE_W-1:0] : cur_word[WORD_W-1:BYTE_W]);
    // The index moves after every one-byte read, or after the B half of a pair.
    assign step     = !two_byte || (half == HALF_B);
    assign next_idx = (word_idx == LAST) ? '0 : word_idx + 1'b1;

    // Word index and pair half, loaded by the host and advanced by reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_idx <= '0;
            half     <= HALF_A;
        end else if (rd_load) begin
            word_idx <= (int'(rd_addr) < NWORDS) ? rd_addr : '0;
            half     <= HALF_A;
        end else if (accept) begin
            if (step) word_idx <= next_idx;
            half <= (two_byte && half == HALF_A) ? HALF_B : HALF_A;
        end
    end

    // Registers the returned byte and its one-cycle valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= accept;
            if (accept) rd_data <= pick;
        end
    end
endmodule

// File: rtl/chstat_reader.sv
// Top: dual-channel status buffer reader. Connects the capture stage, the copy
// unit and the read sequencer, and masks the event flag onto irq.
// Assumes that all inputs are synchronous to clk.
module chstat_reader #(
    parameter int NWORDS = 24,
    parameter int BYTE_W = 8,
    parameter int AW     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_we,
    input  logic [AW-1:0]     cap_addr,
    input  logic [2*BYTE_W-1:0] cap_data,
    input  logic              xfer_req,
    input  logic              burst_active,
    input  logic              buf_sel,
    input  logic              two_byte,
    input  logic              chan_b,
    input  logic              irq_en,
    input  logic              irq_clr,
    input  logic              rd_load,
    input  logic [AW-1:0]     rd_addr,
    input  logic              rd_strobe,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              irq
);
    localparam int WORD_W = 2 * BYTE_W;

    logic [NWORDS*WORD_W-1:0] d_flat;
    logic [NWORDS*WORD_W-1:0] e_flat;
    logic                     irq_flag;
    logic [AW-1:0]            word_idx;

    chstat_capture #(.NWORDS(NWORDS), .WORD_W(WORD_W), .AW(AW)) u_cap (
        .clk(clk), .rst_n(rst_n), .we(cap_we), .waddr(cap_addr),
        .wdata(cap_data), .d_flat(d_flat)
    );

    chstat_xfer #(.NWORDS(NWORDS), .WORD_W(WORD_W)) u_xfer (
        .clk(clk), .rst_n(rst_n), .d_flat(d_flat), .xfer_req(xfer_req),
        .burst_active(burst_active), .irq_clr(irq_clr),
        .e_flat(e_flat), .irq_flag(irq_flag)
    );

    chstat_rdseq #(.NWORDS(NWORDS), .BYTE_W(BYTE_W), .AW(AW)) u_rd (
        .clk(clk), .rst_n(rst_n), .e_flat(e_flat), .rd_load(rd_load),
        .rd_addr(rd_addr), .rd_strobe(rd_strobe), .two_byte(two_byte),
        .chan_b(chan_b), .buf_sel(buf_sel), .rd_data(rd_data),
        .rd_valid(rd_valid), .word_idx(word_idx)
    );

    // The mask gates the output only; the flag itself is kept.
    assign irq = irq_flag && irq_en;
endmodule

// File: rtl/chstat_reader_chk.sv
// Checker: cycle-level properties of the status buffer reader, bound to the top.
module chstat_reader_chk #(
    parameter int NWORDS = 24,
    parameter int BYTE_W = 8,
    parameter int AW     = 5
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       irq,
    input logic                       irq_en,
    input logic                       irq_clr,
    input logic                       irq_flag,
    input logic                       burst_active,
    input logic                       rd_strobe,
    input logic                       rd_load,
    input logic                       rd_valid,
    input logic [BYTE_W-1:0]          rd_data,
    input logic                       buf_sel,
    input logic [AW-1:0]              word_idx,
    input logic [NWORDS*2*BYTE_W-1:0] d_flat,
    input logic [NWORDS*2*BYTE_W-1:0] e_flat
);
    p_mask_gates_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_flag && !irq_clr |=> irq_flag);

    p_same_copy_no_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_flag && (d_flat == e_flat) |=> !irq_flag);

    p_frozen_in_burst_r11: assert property (@(posedge clk) disable iff (!rst_n)
        burst_active |=> $stable(e_flat));

    p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe && !rd_load && buf_sel |=> rd_valid && (rd_data == '0));

    p_valid_on_accept_r14: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe && !rd_load |=> rd_valid);

    p_no_valid_otherwise_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe || rd_load |=> !rd_valid);

    p_idx_in_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        int'(word_idx) < NWORDS);
endmodule

bind chstat_reader chstat_reader_chk #(.NWORDS(NWORDS), .BYTE_W(BYTE_W), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .irq_en(irq_en), .irq_clr(irq_clr),
    .irq_flag(irq_flag), .burst_active(burst_active), .rd_strobe(rd_strobe),
    .rd_load(rd_load), .rd_valid(rd_valid), .rd_data(rd_data), .buf_sel(buf_sel),
    .word_idx(word_idx), .d_flat(d_flat), .e_flat(e_flat)
);

// File: tb/chstat_reader_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks push expected bytes computed from a bench-side
// model of both stages; a monitor pops and compares on every valid byte.
module chstat_reader_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_we = 0, xfer_req = 0, burst_active = 0, buf_sel = 0;
    logic        two_byte = 0, chan_b = 0, irq_en = 0, irq_clr = 0;
    logic        rd_load = 0, rd_strobe = 0;
    logic [4:0]  cap_addr = '0, rd_addr = '0;
    logic [15:0] cap_data = '0;
    logic [7:0]  rd_data;
    logic        rd_valid, irq;

    int errors = 0;
    int checks = 0;

    logic [15:0] d_m [24];
    logic [15:0] e_m [24];
    logic        flag_m = 0;
    logic        pend_m = 0;
    int          idx_m = 0;
    bit          sel_m = 0;

    logic [7:0]  exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    chstat_reader u_dut (
        .clk(clk), .rst_n(rst_n), .cap_we(cap_we), .cap_addr(cap_addr),
        .cap_data(cap_data), .xfer_req(xfer_req), .burst_active(burst_active),
        .buf_sel(buf_sel), .two_byte(two_byte), .chan_b(chan_b),
        .irq_en(irq_en), .irq_clr(irq_clr), .rd_load(rd_load),
        .rd_addr(rd_addr), .rd_strobe(rd_strobe), .rd_data(rd_data),
        .rd_valid(rd_valid), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected byte for each valid byte.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R14 unexpected valid", rd_data, 0);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(rd_data == e, t, rd_data, e);
            end
        end
    end

    task automatic apply_copy();
        if (d_m != e_m) flag_m = 1;
        for (int i = 0; i < 24; i++) e_m[i] = d_m[i];
    endtask

    task automatic cap_write(input int a, input logic [15:0] v);
        @(negedge clk);
        cap_we = 1; cap_addr = 5'(a); cap_data = v;
        @(negedge clk);
        cap_we = 0;
        d_m[a] = v;
    endtask

    task automatic copy_req();
        @(negedge clk);
        xfer_req = 1;
        @(negedge clk);
        xfer_req = 0;
        if (burst_active) pend_m = 1; else apply_copy();
    endtask

    task automatic load(input int a);
        @(negedge clk);
        rd_load = 1; rd_addr = 5'(a);
        @(negedge clk);
        rd_load = 0;
        idx_m = (a < 24) ? a : 0;
        sel_m = 0;
    endtask

    // Driver: one read; pushes the expected byte and advances the model.
    task automatic rd_byte(input string tag);
        logic [7:0] e;
        bit b;
        b = two_byte ? sel_m : chan_b;
        e = buf_sel ? 8'h00 : (b ? e_m[idx_m][7:0] : e_m[idx_m][15:8]);
        @(negedge clk);
        rd_strobe = 1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_strobe = 0;
        if (!two_byte || sel_m) idx_m = (idx_m == 23) ? 0 : idx_m + 1;
        sel_m = two_byte ? !sel_m : 0;
    endtask

    task automatic finish_run();
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R14 all reads answered", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 24; i++) begin d_m[i] = '0; e_m[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(irq == 0, "R1 irq after reset", irq, 0);
        check(rd_valid == 0, "R1 rd_valid after reset", rd_valid, 0);
        check(rd_data == 0, "R1 rd_data after reset", rd_data, 0);
        irq_en = 1;
        rd_byte("R1 first read word0 zero");

        // R2 capture only touches the capture stage
        for (int i = 0; i < 24; i++) cap_write(i, {8'(8'h10 + i), 8'(8'hA0 + i)});
        load(3);
        rd_byte("R2 old value before copy");
        check(irq == 0, "R2 no irq before copy", irq, 0);

        // R3/R4 copy with change
        copy_req();
        check(irq == flag_m, "R4 irq after changing copy", irq, flag_m);
        load(0);
        for (int i = 0; i < 24; i++) rd_byte("R3 R8 one-byte A walk");
        // R8 channel B, R10 wrap
        chan_b = 1;
        load(22);
        for (int i = 0; i < 4; i++) rd_byte("R8 R10 one-byte B wrap");
        chan_b = 0;

        // R6 clear, R5 identical copy
        @(negedge clk); irq_clr = 1;
        @(negedge clk); irq_clr = 0; flag_m = 0;
        check(irq == 0, "R6 cleared by irq_clr", irq, 0);
        copy_req();
        check(irq == 0, "R5 identical copy no irq", irq, 0);

        // R9 two-byte mode with wrap
        two_byte = 1;
        load(22);
        for (int i = 0; i < 6; i++) rd_byte("R9 R10 two-byte pairs");
        // R13 load mid-pair restarts at A
        load(5);
        rd_byte("R9 A half");
        load(9);
        rd_byte("R13 load resets to A");
        two_byte = 0;

        // R7 mask keeps flag
        irq_en = 0;
        cap_write(5, 16'h5AA5);
        copy_req();
        check(irq == 0, "R7 masked irq low", irq, 0);
        @(negedge clk); irq_en = 1;
        @(negedge clk);
        check(irq == 1, "R7 unmask exposes flag", irq, 1);
        // R6 sticky across cycles
        repeat (4) @(negedge clk);
        check(irq == 1, "R6 flag sticky", irq, 1);

        // R6 set wins over simultaneous clear
        cap_write(6, 16'h1234);
        @(negedge clk); irq_clr = 1; xfer_req = 1;
        @(negedge clk); irq_clr = 0; xfer_req = 0; apply_copy(); flag_m = 1;
        check(irq == 1, "R6 set beats clear", irq, 1);
        @(negedge clk); irq_clr = 1;
        @(negedge clk); irq_clr = 0; flag_m = 0;

        // R11 copy deferred during burst
        @(negedge clk); burst_active = 1;
        cap_write(7, 16'hBEEF);
        copy_req();
        load(7);
        rd_byte("R11 old A during burst");
        repeat (5) @(negedge clk);
        check(irq == 0, "R11 no irq during burst", irq, 0);
        load(7); chan_b = 1;
        rd_byte("R11 old B during burst");
        chan_b = 0;
        @(negedge clk); burst_active = 0;
        @(negedge clk);
        if (pend_m) begin apply_copy(); pend_m = 0; end
        check(irq == 1, "R11 deferred copy raises irq", irq, 1);
        load(7);
        rd_byte("R11 new value after burst");

        // R12 unmapped reads give zero and advance
        load(10);
        buf_sel = 1;
        rd_byte("R12 unmapped zero");
        rd_byte("R12 unmapped zero");
        buf_sel = 0;
        rd_byte("R12 index advanced to 12");

        // R13 out-of-range load and load-over-strobe
        load(30);
        rd_byte("R13 out-of-range load to 0");
        @(negedge clk); rd_load = 1; rd_addr = 5'd4; rd_strobe = 1;
        @(negedge clk); rd_load = 0; rd_strobe = 0; idx_m = 4; sel_m = 0;
        check(rd_valid == 0, "R13 strobe dropped under load", rd_valid, 0);
        rd_byte("R13 word4 after dropped read");

        // R14 valid lasts one cycle
        rd_byte("R14 byte");
        @(negedge clk);
        check(rd_valid == 0, "R14 valid single cycle", rd_valid, 0);

        finish_run();
    end
endmodule